// File: doc/BRIEF.md
# I2C Register Transaction Sequencer

This block drives a bit-level I2C engine to carry out whole transactions: a presence probe, a register write and a register read. A host presents one request (operation, 7-bit device address, register address of zero to `MAX_ALEN` bytes, byte count). The sequencer then issues START, STOP, byte-write and byte-read commands to the engine one at a time. It waits for each command to finish and steers the rest of the transaction from the acknowledge bit the engine returns.

Write data is pulled from the host one byte at a time through a request/valid handshake. Read data is pushed out one byte per strobe. At the end the block gives a completion pulse, an error flag and a count of data bytes the target refused. Between the address phase and the data phase of a register read, the bus is released with a full STOP and taken again with a fresh START. A build-time mask can fold register-address bits above the address length into the low bits of the device address. Some small EEPROMs need this, so that one device looks like several 256-byte pages.

Top module: `i2c_xact_seq`

## Requirements
- R1: Operation 0 (probe; code 3 behaves the same) issues START, a write of {dev,0}, then STOP; `resp_err` is 1 exactly when that byte was NACKed.
- R2: In a write (op 1), or a read (op 2) with nonzero address length, a NACK on the {dev,0} byte is followed by STOP and completion with `resp_err`=1, with no further bytes.
- R3: Register address bytes are written after {dev,0}, `req_alen` of them, most significant byte first.
- R4: A NACK on any register address byte ends the transaction with `resp_err`=1 and no STOP command.
- R5: A read with nonzero address length issues STOP then START after the last address byte, then writes {dev,1}.
- R6: A read with address length 0 issues START and then {dev,1} directly, with no {dev,0} and no address bytes.
- R7: Each read byte is a read command (engine command code 3) with `eng_rd_nack`=0, except the last, which has `eng_rd_nack`=1. Each byte appears on `rd_data` with `rd_valid` high for one cycle, in the cycle after the engine reports it done. A STOP follows the last byte.
- R8: In a write, `wr_req` stays high until `wr_valid`, and each accepted byte is written in order. A NACK on a data byte adds one to `resp_fails` and does not stop the transfer, which ends with STOP.
- R9: With a nonzero `OVF_MASK`, the device address used on the bus is `req_dev | ((req_addr >> 8*req_alen) & OVF_MASK)`, in both the {dev,0} and {dev,1} bytes.
- R10: The acknowledge bit returned for the {dev,1} byte is ignored: reading proceeds and `resp_err` stays 0.
- R11: A byte count of 0 performs only the addressing phase and then STOP, with no data commands.
- R12: After reset and after completion, `req_ready` is 1. `resp_done` pulses for one cycle after the final STOP (or after the failing address byte), and `req_ready` returns the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while `req_ready` is high |
| req_ready | output | 1 | Sequencer idle |
| req_op | input | 2 | 0 probe, 1 write, 2 read, 3 probe |
| req_dev | input | 7 | Device address |
| req_addr | input | 8*MAX_ALEN | Register address |
| req_alen | input | clog2(MAX_ALEN+1) | Register address length in bytes |
| req_len | input | LEN_W | Data byte count |
| wr_req | output | 1 | Next write byte wanted |
| wr_valid | input | 1 | Write byte present |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| resp_done | output | 1 | Transaction complete pulse |
| resp_err | output | 1 | Address-phase NACK (probe: device absent) |
| resp_fails | output | LEN_W | NACKed write data bytes |
| eng_cmd_valid | output | 1 | Command issue pulse to the engine |
| eng_cmd | output | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| eng_wbyte | output | 8 | Byte to write |
| eng_rd_nack | output | 1 | Level to drive in the acknowledge slot of a read |
| eng_done | input | 1 | Engine finished the current command |
| eng_rx_nack | input | 1 | Acknowledge bit sampled after a byte write (1 = NACK) |
| eng_rx_byte | input | 8 | Byte received by a read |

## Verification
The bench builds the block with `MAX_ALEN`=4, `LEN_W`=8 and `OVF_MASK`=7'h03. It can therefore reach four-byte register addresses, where the fold shifts out every address bit. It also reaches the shorter lengths, where two address bits land in the device address. An engine model answers each command after a random latency and takes NACKs from a per-transaction plan. This exposes every abort point: device byte, each address byte, the ignored read-phase device byte and individual data bytes.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

   typedef enum logic [1:0] {
      CMD_START = 2'd0,
      CMD_STOP  = 2'd1,
      CMD_WRITE = 2'd2,
      CMD_READ  = 2'd3
   } eng_cmd_e;

   typedef enum logic [1:0] {
      OP_PROBE = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2,
      OP_ALT   = 2'd3
   } req_op_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_START1,
      S_DEVW,
      S_ADDR,
      S_STOP1,
      S_START2,
      S_DEVR,
      S_RDATA,
      S_WREQ,
      S_WDATA,
      S_STOP_END,
      S_DONE
   } seq_state_e;

endpackage

// File: rtl/i2c_seq_addr_path.sv
module i2c_seq_addr_path #(
   parameter int          MAX_ALEN = 4,
   parameter logic [6:0]  OVF_MASK = 7'h00,
   localparam int         ADDR_W   = 8 * MAX_ALEN,
   localparam int         ALEN_W   = $clog2(MAX_ALEN + 1)
) (
   input  logic [6:0]        req_dev,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ALEN_W-1:0] req_alen,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [ALEN_W-1:0] idx_q,
   output logic [6:0]        dev_fold,
   output logic [7:0]        addr_byte
);

   // byte selector for the register address, index counts down to 0
   logic [ADDR_W-1:0] byte_sh;
   assign byte_sh   = addr_q >> {idx_q, 3'b000};
   assign addr_byte = byte_sh[7:0];

   generate
      if (OVF_MASK != 7'h00) begin : g_fold
         // pad so a shift by the full address width yields zero
         logic [ADDR_W+7:0] ext;
         logic [ADDR_W+7:0] upper;
         assign ext      = {8'h00, req_addr};
         assign upper    = ext >> {req_alen, 3'b000};
         assign dev_fold = req_dev | (upper[6:0] & OVF_MASK);
      end else begin : g_plain
         logic unused_fold;
         assign unused_fold = ^{req_addr, req_alen};
         assign dev_fold    = req_dev;
      end
   endgenerate

endmodule

// File: rtl/i2c_seq_fail_ctr.sv
module i2c_seq_fail_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc && (cnt != '1))
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
   import i2c_seq_pkg::*;
#(
   parameter int MAX_ALEN = 4,
   parameter int LEN_W    = 8,
   localparam int ADDR_W  = 8 * MAX_ALEN,
   localparam int ALEN_W  = $clog2(MAX_ALEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [6:0]        dev_fold,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ALEN_W-1:0] req_alen,
   input  logic [LEN_W-1:0]  req_len,
   output logic              wr_req,
   input  logic              wr_valid,
   input  logic [7:0]        wr_data,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              resp_done,
   output logic              resp_err,
   output logic              eng_cmd_valid,
   output logic [1:0]        eng_cmd,
   output logic [7:0]        eng_wbyte,
   output logic              eng_rd_nack,
   input  logic              eng_done,
   input  logic              eng_rx_nack,
   input  logic [7:0]        eng_rx_byte,
   output logic [ADDR_W-1:0] addr_q,
   output logic [ALEN_W-1:0] idx_q,
   input  logic [7:0]        addr_byte,
   output logic              accept,
   output logic              fail_inc
);

   seq_state_e        state;
   req_op_e           op_q;
   logic              pend;
   logic [6:0]        dev_q;
   logic [ALEN_W-1:0] alen_q;
   logic [LEN_W-1:0]  rem_q;
   logic [7:0]        wbyte_q;
   logic              err_q;
   logic              step;
   logic              cmd_st;
   eng_cmd_e          cmd_sel;
   logic              last_rem;

   assign step      = pend && eng_done;
   assign last_rem  = (rem_q == LEN_W'(1));
   assign req_ready = (state == S_IDLE);
   assign accept    = req_ready && req_valid;
   assign wr_req    = (state == S_WREQ);
   assign resp_done = (state == S_DONE);
   assign resp_err  = err_q;
   assign fail_inc  = step && (state == S_WDATA) && eng_rx_nack;

   always_comb begin
      cmd_st    = 1'b0;
      cmd_sel   = CMD_WRITE;
      eng_wbyte = 8'h00;
      case (state)
         S_START1, S_START2: begin
            cmd_st  = 1'b1;
            cmd_sel = CMD_START;
         end
         S_STOP1, S_STOP_END: begin
            cmd_st  = 1'b1;
            cmd_sel = CMD_STOP;
         end
         S_DEVW: begin
            cmd_st    = 1'b1;
            eng_wbyte = {dev_q, 1'b0};
         end
         S_ADDR: begin
            cmd_st    = 1'b1;
            eng_wbyte = addr_byte;
         end
         S_DEVR: begin
            cmd_st    = 1'b1;
            eng_wbyte = {dev_q, 1'b1};
         end
         S_WDATA: begin
            cmd_st    = 1'b1;
            eng_wbyte = wbyte_q;
         end
         S_RDATA: begin
            cmd_st  = 1'b1;
            cmd_sel = CMD_READ;
         end
         default: ;
      endcase
   end

   assign eng_cmd_valid = cmd_st && !pend;
   assign eng_cmd       = cmd_sel;
   assign eng_rd_nack   = (state == S_RDATA) && last_rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         op_q     <= OP_PROBE;
         pend     <= 1'b0;
         dev_q    <= '0;
         addr_q   <= '0;
         alen_q   <= '0;
         idx_q    <= '0;
         rem_q    <= '0;
         wbyte_q  <= '0;
         err_q    <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= 1'b0;
         if (eng_cmd_valid) pend <= 1'b1;
         if (step)          pend <= 1'b0;
         case (state)
            S_IDLE: if (req_valid) begin
               op_q   <= (req_op == OP_ALT) ? OP_PROBE : req_op_e'(req_op);
               dev_q  <= dev_fold;
               addr_q <= req_addr;
               alen_q <= req_alen;
               rem_q  <= req_len;
               err_q  <= 1'b0;
               state  <= S_START1;
            end
            S_START1: if (step)
               state <= (op_q == OP_READ && alen_q == '0) ? S_DEVR : S_DEVW;
            S_DEVW: if (step) begin
               if (eng_rx_nack) begin
                  err_q <= 1'b1;
                  state <= S_STOP_END;
               end else if (op_q == OP_PROBE)
                  state <= S_STOP_END;
               else if (alen_q != '0) begin
                  idx_q <= alen_q - 1'b1;
                  state <= S_ADDR;
               end else
                  state <= (rem_q == '0) ? S_STOP_END : S_WREQ;
            end
            S_ADDR: if (step) begin
               if (eng_rx_nack) begin
                  err_q <= 1'b1;
                  state <= S_DONE;
               end else if (idx_q != '0)
                  idx_q <= idx_q - 1'b1;
               else if (op_q == OP_READ)
                  state <= S_STOP1;
               else
                  state <= (rem_q == '0) ? S_STOP_END : S_WREQ;
            end
            S_STOP1:  if (step) state <= S_START2;
            S_START2: if (step) state <= S_DEVR;
            S_DEVR:   if (step) state <= (rem_q == '0) ? S_STOP_END : S_RDATA;
            S_RDATA: if (step) begin
               rd_valid <= 1'b1;
               rd_data  <= eng_rx_byte;
               rem_q    <= rem_q - 1'b1;
               if (last_rem) state <= S_STOP_END;
            end
            S_WREQ: if (wr_valid) begin
               wbyte_q <= wr_data;
               state   <= S_WDATA;
            end
            S_WDATA: if (step) begin
               rem_q <= rem_q - 1'b1;
               state <= last_rem ? S_STOP_END : S_WREQ;
            end
            S_STOP_END: if (step) state <= S_DONE;
            S_DONE:     state <= S_IDLE;
            default:    state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq #(
   parameter int          MAX_ALEN = 4,
   parameter int          LEN_W    = 8,
   parameter logic [6:0]  OVF_MASK = 7'h00,
   localparam int         ADDR_W   = 8 * MAX_ALEN,
   localparam int         ALEN_W   = $clog2(MAX_ALEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [6:0]        req_dev,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ALEN_W-1:0] req_alen,
   input  logic [LEN_W-1:0]  req_len,
   output logic              wr_req,
   input  logic              wr_valid,
   input  logic [7:0]        wr_data,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              resp_done,
   output logic              resp_err,
   output logic [LEN_W-1:0]  resp_fails,
   output logic              eng_cmd_valid,
   output logic [1:0]        eng_cmd,
   output logic [7:0]        eng_wbyte,
   output logic              eng_rd_nack,
   input  logic              eng_done,
   input  logic              eng_rx_nack,
   input  logic [7:0]        eng_rx_byte
);

   generate
      if (MAX_ALEN < 1 || MAX_ALEN > 4) begin : g_bad_alen
         $error("MAX_ALEN must lie in 1..4");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("LEN_W must lie in 1..16");
      end
   endgenerate

   logic [6:0]        dev_fold;
   logic [7:0]        addr_byte;
   logic [ADDR_W-1:0] addr_q;
   logic [ALEN_W-1:0] idx_q;
   logic              accept;
   logic              fail_inc;

   i2c_seq_addr_path #(
      .MAX_ALEN (MAX_ALEN),
      .OVF_MASK (OVF_MASK)
   ) u_addr (
      .req_dev   (req_dev),
      .req_addr  (req_addr),
      .req_alen  (req_alen),
      .addr_q    (addr_q),
      .idx_q     (idx_q),
      .dev_fold  (dev_fold),
      .addr_byte (addr_byte)
   );

   i2c_seq_ctrl #(
      .MAX_ALEN (MAX_ALEN),
      .LEN_W    (LEN_W)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_op        (req_op),
      .dev_fold      (dev_fold),
      .req_addr      (req_addr),
      .req_alen      (req_alen),
      .req_len       (req_len),
      .wr_req        (wr_req),
      .wr_valid      (wr_valid),
      .wr_data       (wr_data),
      .rd_valid      (rd_valid),
      .rd_data       (rd_data),
      .resp_done     (resp_done),
      .resp_err      (resp_err),
      .eng_cmd_valid (eng_cmd_valid),
      .eng_cmd       (eng_cmd),
      .eng_wbyte     (eng_wbyte),
      .eng_rd_nack   (eng_rd_nack),
      .eng_done      (eng_done),
      .eng_rx_nack   (eng_rx_nack),
      .eng_rx_byte   (eng_rx_byte),
      .addr_q        (addr_q),
      .idx_q         (idx_q),
      .addr_byte     (addr_byte),
      .accept        (accept),
      .fail_inc      (fail_inc)
   );

   i2c_seq_fail_ctr #(
      .CNT_W (LEN_W)
   ) u_fails (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .inc   (fail_inc),
      .cnt   (resp_fails)
   );

endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       wr_req,
   input logic       wr_valid,
   input logic       rd_valid,
   input logic [7:0] rd_data,
   input logic       resp_done,
   input logic       eng_cmd_valid,
   input logic [1:0] eng_cmd,
   input logic       eng_rd_nack,
   input logic       eng_done,
   input logic [7:0] eng_rx_byte
);

   // R12
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   // R12
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_done |=> req_ready);

   // R7
   rd_from_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(eng_done) && rd_data == $past(eng_rx_byte)));

   // R7
   rd_nack_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_valid && eng_rd_nack |-> eng_cmd == 2'd3);

   // R8
   wr_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && !wr_valid |=> wr_req);

endmodule

bind i2c_xact_seq i2c_seq_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .wr_req        (wr_req),
   .wr_valid      (wr_valid),
   .rd_valid      (rd_valid),
   .rd_data       (rd_data),
   .resp_done     (resp_done),
   .eng_cmd_valid (eng_cmd_valid),
   .eng_cmd       (eng_cmd),
   .eng_rd_nack   (eng_rd_nack),
   .eng_done      (eng_done),
   .eng_rx_byte   (eng_rx_byte)
);

// File: tb/i2c_xact_seq_tb.sv
module i2c_xact_seq_tb;

   localparam int         MAX_ALEN = 4;
   localparam int         LEN_W    = 8;
   localparam logic [6:0] MASK     = 7'h03;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = 2'd0;
   logic [6:0]  req_dev = 7'd0;
   logic [31:0] req_addr = 32'd0;
   logic [2:0]  req_alen = 3'd0;
   logic [7:0]  req_len = 8'd0;
   logic        wr_req;
   logic        wr_valid = 1'b0;
   logic [7:0]  wr_data = 8'd0;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic        resp_done;
   logic        resp_err;
   logic [7:0]  resp_fails;
   logic        eng_cmd_valid;
   logic [1:0]  eng_cmd;
   logic [7:0]  eng_wbyte;
   logic        eng_rd_nack;
   logic        eng_done = 1'b0;
   logic        eng_rx_nack = 1'b0;
   logic [7:0]  eng_rx_byte = 8'd0;

   always #2 clk = ~clk;

   i2c_xact_seq #(.MAX_ALEN(MAX_ALEN), .LEN_W(LEN_W), .OVF_MASK(MASK)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_dev(req_dev), .req_addr(req_addr), .req_alen(req_alen),
      .req_len(req_len), .wr_req(wr_req), .wr_valid(wr_valid), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_data(rd_data), .resp_done(resp_done),
      .resp_err(resp_err), .resp_fails(resp_fails), .eng_cmd_valid(eng_cmd_valid),
      .eng_cmd(eng_cmd), .eng_wbyte(eng_wbyte), .eng_rd_nack(eng_rd_nack),
      .eng_done(eng_done), .eng_rx_nack(eng_rx_nack), .eng_rx_byte(eng_rx_byte));

   int errors = 0;
   int checks = 0;

   // NACK plan, indexed by byte-write command number within a transaction
   bit        plan [0:63];
   logic [7:0] wbuf [0:63];

   // engine model log
   logic [1:0] log_cmd [0:63];
   logic [7:0] log_byte [0:63];
   logic       log_rn [0:63];
   int         log_n = 0;
   int         m_wc = 0;
   logic [7:0] mrd [0:63];
   int         mrd_n = 0;
   bit         m_busy = 0;
   int         m_lat = 0;
   logic [7:0] rd_got [0:63];
   int         rd_n = 0;
   int         widx = 0;

   // expected command list
   logic [1:0] exp_cmd [0:63];
   logic [7:0] exp_byte [0:63];
   logic       exp_rn [0:63];
   int         exp_n;
   bit         exp_err;
   int         exp_fails;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // engine model: one command at a time, random latency
   initial begin
      forever begin
         @(negedge clk);
         eng_done = 1'b0;
         if (m_busy) begin
            if (m_lat == 0) begin
               eng_done = 1'b1;
               m_busy = 0;
            end else m_lat--;
         end else if (eng_cmd_valid) begin
            if (log_n < 64) begin
               log_cmd[log_n] = eng_cmd;
               log_byte[log_n] = eng_wbyte;
               log_rn[log_n] = eng_rd_nack;
               log_n++;
            end
            eng_rx_nack = 1'b0;
            if (eng_cmd == 2'd2) begin
               if (m_wc < 64) eng_rx_nack = plan[m_wc];
               m_wc++;
            end
            if (eng_cmd == 2'd3) begin
               eng_rx_byte = 8'($urandom);
               if (mrd_n < 64) mrd[mrd_n] = eng_rx_byte;
               mrd_n++;
            end
            m_busy = 1;
            m_lat = int'($urandom % 3);
         end
      end
   end

   // write-data source and read-data monitor
   initial begin
      forever begin
         @(negedge clk);
         if (wr_req && !wr_valid) begin
            wr_valid = 1'b1;
            wr_data = wbuf[widx % 64];
            widx++;
         end else wr_valid = 1'b0;
         if (rd_valid) begin
            if (rd_n < 64) rd_got[rd_n] = rd_data;
            rd_n++;
         end
      end
   end

   task automatic push(input logic [1:0] c, input logic [7:0] b, input logic rn);
      exp_cmd[exp_n] = c;
      exp_byte[exp_n] = b;
      exp_rn[exp_n] = rn;
      exp_n++;
   endtask

   task automatic build_exp(input int op, input logic [6:0] dev, input logic [31:0] addr,
                            input int alen, input int len);
      logic [39:0] ext;
      logic [6:0]  fdev;
      int wc;
      exp_n = 0; exp_err = 0; exp_fails = 0; wc = 0;
      ext = {8'h00, addr} >> (8 * alen);
      fdev = dev | (ext[6:0] & MASK);
      push(2'd0, 8'h00, 1'b0);
      if (op == 0) begin
         push(2'd2, {fdev, 1'b0}, 1'b0);
         exp_err = plan[0];
         push(2'd1, 8'h00, 1'b0);
         return;
      end
      if (!(op == 2 && alen == 0)) begin
         push(2'd2, {fdev, 1'b0}, 1'b0);
         if (plan[wc]) begin
            exp_err = 1;
            push(2'd1, 8'h00, 1'b0);
            return;
         end
         wc++;
         for (int i = alen - 1; i >= 0; i--) begin
            push(2'd2, 8'(addr >> (8 * i)), 1'b0);
            if (plan[wc]) begin
               exp_err = 1;
               return;
            end
            wc++;
         end
      end
      if (op == 2) begin
         if (alen > 0) begin
            push(2'd1, 8'h00, 1'b0);
            push(2'd0, 8'h00, 1'b0);
         end
         push(2'd2, {fdev, 1'b1}, 1'b0);
         wc++;
         for (int k = 0; k < len; k++) push(2'd3, 8'h00, (k == len - 1) ? 1'b1 : 1'b0);
      end else begin
         for (int k = 0; k < len; k++) begin
            push(2'd2, wbuf[k], 1'b0);
            if (plan[wc]) exp_fails++;
            wc++;
         end
      end
      push(2'd1, 8'h00, 1'b0);
   endtask

   task automatic run_txn(input int op, input logic [6:0] dev, input logic [31:0] addr,
                          input int alen, input int len, input string tag);
      int  mism;
      int  first;
      bit  seen;
      for (int k = 0; k < 64; k++) wbuf[k] = 8'($urandom);
      build_exp(op, dev, addr, alen, len);
      log_n = 0; m_wc = 0; mrd_n = 0; rd_n = 0; widx = 0;
      @(negedge clk);
      req_op = 2'(op); req_dev = dev; req_addr = addr;
      req_alen = 3'(alen); req_len = 8'(len); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      seen = 0;
      for (int c = 0; c < 4000; c++) begin
         if (resp_done) begin
            seen = 1;
            break;
         end
         @(negedge clk);
      end
      check(seen, tag, "completion seen", longint'(seen), 1);
      if (!seen) return;
      check(resp_err == exp_err, tag, "resp_err", longint'(resp_err), longint'(exp_err));
      if (op == 1)
         check(int'(resp_fails) == exp_fails, tag, "resp_fails", longint'(resp_fails),
               longint'(exp_fails));
      check(log_n == exp_n, tag, "command count", longint'(log_n), longint'(exp_n));
      mism = 0; first = -1;
      for (int k = 0; k < exp_n && k < log_n; k++) begin
         if (log_cmd[k] != exp_cmd[k] ||
             (exp_cmd[k] == 2'd2 && log_byte[k] != exp_byte[k]) ||
             (exp_cmd[k] == 2'd3 && log_rn[k] != exp_rn[k])) begin
            mism++;
            if (first < 0) first = k;
         end
      end
      if (first >= 0)
         check(0, tag, $sformatf("command %0d {cmd,byte,rn}", first),
               longint'({log_cmd[first], log_byte[first], log_rn[first]}),
               longint'({exp_cmd[first], exp_byte[first], exp_rn[first]}));
      else
         check(1, tag, "command sequence", 0, 0);
      if (op == 2 && !exp_err) begin
         mism = 0;
         for (int k = 0; k < rd_n && k < mrd_n && k < 64; k++)
            if (rd_got[k] != mrd[k]) mism++;
         check(rd_n == len && mism == 0, tag, "read data (count,mismatch)",
               longint'({rd_n, mism}), longint'({len, 0}));
      end
      @(negedge clk);
      check(req_ready == 1'b1, "R12", "ready after done", longint'(req_ready), 1);
      for (int k = 0; k < 64; k++) plan[k] = 0;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int k = 0; k < 64; k++) plan[k] = 0;
      repeat (3) @(negedge clk);
      // R12 reset state
      check(req_ready == 1'b1, "R12", "reset req_ready", longint'(req_ready), 1);
      check(resp_done == 1'b0, "R12", "reset resp_done", longint'(resp_done), 0);
      check(eng_cmd_valid == 1'b0 && wr_req == 1'b0, "R12", "reset idle outputs",
            longint'({eng_cmd_valid, wr_req}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_txn(0, 7'h50, 32'h0, 0, 0, "R1");              // probe present
      plan[0] = 1;
      run_txn(3, 7'h21, 32'h0, 0, 0, "R1");              // probe absent, alternate code
      plan[0] = 1;
      run_txn(1, 7'h10, 32'h0000_1234, 2, 3, "R2");      // write device NACK
      plan[0] = 1;
      run_txn(2, 7'h10, 32'h0000_0044, 1, 2, "R2");      // read device NACK
      plan[2] = 1;
      run_txn(1, 7'h30, 32'h00AB_CDEF, 3, 2, "R4");      // second address byte NACK
      plan[1] = 1;
      run_txn(2, 7'h30, 32'h0000_0012, 1, 2, "R4");      // read address NACK
      run_txn(1, 7'h40, 32'h1122_3344, 4, 1, "R3");      // MSB first, four bytes
      run_txn(2, 7'h44, 32'h0000_BEEF, 2, 3, "R5");      // STOP/START turnaround
      run_txn(2, 7'h44, 32'h0, 0, 2, "R6");              // no addressing phase
      run_txn(2, 7'h44, 32'h0000_0007, 1, 1, "R7");      // single byte gets NACK
      plan[2] = 1;
      run_txn(2, 7'h48, 32'h0000_0009, 1, 2, "R10");     // read-phase NACK ignored
      plan[3] = 1; plan[5] = 1;
      run_txn(1, 7'h4C, 32'h0000_0033, 1, 4, "R8");      // two data NACKs counted
      run_txn(1, 7'h4C, 32'h0000_0033, 1, 0, "R11");     // write, no data
      run_txn(2, 7'h4C, 32'h0000_0033, 1, 0, "R11");     // read, no data
      run_txn(2, 7'h50, 32'h0000_02AB, 1, 1, "R9");      // fold bit 1
      run_txn(1, 7'h50, 32'h0000_0005, 0, 1, "R9");      // fold with no address bytes

      for (int t = 0; t < 60; t++) begin
         int op, alen, len;
         op = int'($urandom % 3);
         alen = int'($urandom % 5);
         len = int'($urandom % 9);
         for (int k = 0; k < 64; k++) plan[k] = (($urandom % 10) == 0);
         run_txn(op, 7'($urandom), $urandom, alen, len,
                 (op == 0) ? "R1" : (op == 1) ? "R8" : "R7");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule